// File: doc/BRIEF.md
# Event Channel Generator Router

This block routes event generator signals onto a bank of event channels. Each channel has its own 8-bit select register. The value in that register picks one generator signal from the surrounding peripherals and drives it onto that channel's output. The generators include single-bit signals from timers, the converter, the comparator, the logic tables, the serial clocks and the debug link. There are also eight periodic divider taps and three 8-bit pin buses, and each pin bus has a per-pin input-enable mask.

A select code does not mean the same thing on every channel. The divider-tap codes pick slow taps on even channels and fast taps on odd channels. The two pin-code ranges pick a different port depending on which pair of channels (0–1, 2–3 or 4–5) the channel belongs to. For this reason every channel has its own decoder, built for its index. The select code 0x00 and any code that a channel does not define both give a constant zero. Software writes the registers over a simple address/data bus and can read them back.

Every channel output is registered. Sources classed as asynchronous (counter, divider taps, logic tables, comparator, pins) pass through an extra synchronizing flop when the SYNC_ASYNC parameter is set. Synchronous sources take one register stage.

Top module: `evt_route_top`

## Requirements
- R1: While and after reset, every select register reads 0x00 and every channel output is 0.
- R2: A write with wr_en high to address 0x10+n (n = 0..5) loads channel n's register on that clock edge. rd_data returns the register at rd_addr one cycle later. Reads of any other address return 0x00. Writes to any other address change no register.
- R3: Code 0x00, and any code not listed in R4–R7 for that channel, drives a constant 0 on the channel.
- R4: On every channel, these codes select the listed sources: 0x01 dbg_sync; 0x06 rtc_ovf; 0x07 rtc_cmp; 0x10..0x13 lut_out[0..3]; 0x20 ac_out; 0x24/0x25/0x26 adc_evt[0]/[1]/[2]; 0x60/0x61 usart_xck[0]/[1]; 0x68 spi_sck; 0x80/0x81/0x84/0x85/0x86 tca_evt[0]/[1]/[2]/[3]/[4]; 0xA0..0xA3 tcb_evt[0..3].
- R5: pit_tap[k] is the divide-by-2^(k+6) tap. On even channels, codes 0x08..0x0B select pit_tap[7..4] (divide by 8192, 4096, 2048, 1024). On odd channels, the same codes select pit_tap[3..0] (divide by 512, 256, 128, 64).
- R6: Codes 0x40+p (p = 0..7) select pin p of port A on channels 0–1, port C on channels 2–3, and port B on channels 4–5.
- R7: Codes 0x48+p (p = 0..7) select pin p of port B on channels 0–1, port A on channels 2–3, and port C on channels 4–5.
- R8: A pin source reads 0 whenever the matching bit of that port's input-enable mask (ien_a/ien_b/ien_c) is 0.
- R9: For a synchronous source (codes 0x01, 0x24–0x26, 0x60/0x61/0x68, 0x8x, 0xAx), the channel output equals the source as it was one clock edge earlier.
- R10: With SYNC_ASYNC=1 (the default), for an asynchronous source (codes 0x06–0x0B, 0x10–0x13, 0x20, 0x40–0x4F), the channel output equals the source as it was two clock edges earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW (8) | Write address |
| wr_data | input | DW (8) | Write data |
| rd_addr | input | AW (8) | Read address |
| rd_data | output | DW (8) | Registered read data |
| dbg_sync | input | 1 | Debug sync-character detect |
| rtc_ovf | input | 1 | Counter overflow |
| rtc_cmp | input | 1 | Counter compare match |
| pit_tap | input | 8 | Periodic divider taps, bit k = divide by 2^(k+6) |
| lut_out | input | 4 | Logic table outputs |
| ac_out | input | 1 | Comparator output |
| adc_evt | input | 3 | Converter result ready, sample ready, window match |
| usart_xck | input | 2 | Serial host clocks |
| spi_sck | input | 1 | SPI host clock |
| tca_evt | input | 5 | Timer A overflow, high underflow, compare 0..2 |
| tcb_evt | input | 4 | Timer B0 capture/overflow, B1 capture/overflow |
| pin_a | input | NPIN (8) | Port A pin levels |
| pin_b | input | NPIN (8) | Port B pin levels |
| pin_c | input | NPIN (8) | Port C pin levels |
| ien_a | input | NPIN (8) | Port A input-enable mask |
| ien_b | input | NPIN (8) | Port B input-enable mask |
| ien_c | input | NPIN (8) | Port C input-enable mask |
| evt_out | output | NCH (6) | One event output per channel |

## Verification
The bench aims at the per-channel decode differences. It runs the same divider code on an even and an odd channel, and the same pin code on every channel pair. A design that shares one decoder across channels would route the wrong tap or the wrong port, and the output would stay low when the expected source toggles. Undefined codes are driven with a live source behind them, so a decoder that aliases on partial bits would pass an event through. Pin masking, out-of-range register writes and the one-versus-two-cycle latency of synchronous and asynchronous sources are each checked on their own. A missing or extra synchronizer stage would show the edge one cycle early or late.

// File: rtl/evt_route_pkg.sv
package evt_route_pkg;
  localparam int CODE_W = 8;
  localparam int NPIT   = 8;
  localparam int NLUT   = 4;
  localparam int NADC   = 3;
  localparam int NUSART = 2;
  localparam int NTCA   = 5;
  localparam int NTCB   = 4;
  localparam int NPORT  = 3;

  localparam int PORT_A = 0;
  localparam int PORT_B = 1;
  localparam int PORT_C = 2;

  // Bundle of single-bit generators seen by every channel decoder
  typedef struct packed {
    logic              dbg;
    logic              rtc_ovf;
    logic              rtc_cmp;
    logic [NPIT-1:0]   pit;
    logic [NLUT-1:0]   lut;
    logic              ac;
    logic [NADC-1:0]   adc;
    logic [NUSART-1:0] usart;
    logic              spi;
    logic [NTCA-1:0]   tca;
    logic [NTCB-1:0]   tcb;
  } gen_bus_t;
endpackage

// File: rtl/evt_sel_regs.sv
module evt_sel_regs #(
  parameter int NCH  = 6,
  parameter int AW   = 8,
  parameter int DW   = 8,
  parameter int BASE = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [AW-1:0]           wr_addr,
  input  logic [DW-1:0]           wr_data,
  input  logic [AW-1:0]           rd_addr,
  output logic [DW-1:0]           rd_data,
  output logic [NCH-1:0][DW-1:0]  sel_o
);
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1;

  logic [NCH-1:0][DW-1:0] sel_q;
  logic [DW-1:0]          rd_q;
  logic [AW-1:0]          rd_off;
  logic                   rd_hit;

  genvar i;
  generate
    for (i = 0; i < NCH; i++) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) sel_q[i] <= '0;
        else if (wr_en && wr_addr == AW'(BASE + i)) sel_q[i] <= wr_data;
      end

      p_wr_load_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == AW'(BASE + i)) |=> (sel_q[i] == $past(wr_data)));
    end
  endgenerate

  assign rd_off = rd_addr - AW'(BASE);
  assign rd_hit = (rd_addr >= AW'(BASE)) && (rd_off < AW'(NCH));

  always_ff @(posedge clk) begin
    if (rst)         rd_q <= '0;
    else if (rd_hit) rd_q <= sel_q[rd_off[IW-1:0]];
    else             rd_q <= '0;
  end

  assign rd_data = rd_q;
  assign sel_o   = sel_q;

  p_rst_clear_r1: assert property (@(posedge clk)
    rst |=> (sel_q == '0 && rd_q == '0));
endmodule

// File: rtl/evt_chan_decode.sv
module evt_chan_decode
  import evt_route_pkg::*;
#(
  parameter int CH   = 0,
  parameter int NPIN = 8
) (
  input  logic [CODE_W-1:0]           code_i,
  input  gen_bus_t                    gen_i,
  input  logic [NPORT-1:0][NPIN-1:0]  pin_i,
  output logic                        hit_o,
  output logic                        async_o
);
  localparam int PW   = $clog2(NPIN);
  localparam bit ODD  = (CH % 2) == 1;
  localparam int PAIR = CH / 2;
  // Port reached by the low (0x40..) and high (0x48..) pin ranges for this pair
  localparam int LO_PORT = (PAIR == 0) ? PORT_A : (PAIR == 1) ? PORT_C : PORT_B;
  localparam int HI_PORT = (PAIR == 0) ? PORT_B : (PAIR == 1) ? PORT_A : PORT_C;

  logic [PW-1:0] pin_idx;
  logic [2:0]    tap_idx;

  assign pin_idx = code_i[PW-1:0];
  // even channel: 7 - c, odd channel: 3 - c
  assign tap_idx = {!ODD, ~code_i[1:0]};

  always_comb begin
    hit_o   = 1'b0;
    async_o = 1'b0;
    if (code_i[7:4] == 4'h4) begin
      async_o = 1'b1;
      hit_o   = code_i[3] ? pin_i[HI_PORT][pin_idx] : pin_i[LO_PORT][pin_idx];
    end else if (code_i[7:2] == 6'b000010) begin
      async_o = 1'b1;
      hit_o   = gen_i.pit[tap_idx];
    end else begin
      case (code_i)
        8'h01: hit_o = gen_i.dbg;
        8'h06: begin hit_o = gen_i.rtc_ovf; async_o = 1'b1; end
        8'h07: begin hit_o = gen_i.rtc_cmp; async_o = 1'b1; end
        8'h10, 8'h11, 8'h12, 8'h13: begin
          hit_o = gen_i.lut[code_i[1:0]]; async_o = 1'b1;
        end
        8'h20: begin hit_o = gen_i.ac; async_o = 1'b1; end
        8'h24: hit_o = gen_i.adc[0];
        8'h25: hit_o = gen_i.adc[1];
        8'h26: hit_o = gen_i.adc[2];
        8'h60: hit_o = gen_i.usart[0];
        8'h61: hit_o = gen_i.usart[1];
        8'h68: hit_o = gen_i.spi;
        8'h80: hit_o = gen_i.tca[0];
        8'h81: hit_o = gen_i.tca[1];
        8'h84: hit_o = gen_i.tca[2];
        8'h85: hit_o = gen_i.tca[3];
        8'h86: hit_o = gen_i.tca[4];
        8'hA0, 8'hA1, 8'hA2, 8'hA3: hit_o = gen_i.tcb[code_i[1:0]];
        default: hit_o = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/evt_chan_sync.sv
module evt_chan_sync #(
  parameter bit SYNC_ASYNC = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din_i,
  input  logic async_i,
  output logic out_o
);
  logic       out_q;
  logic [1:0] arm_q;

  generate
    if (SYNC_ASYNC) begin : g_sync
      logic s1_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          s1_q  <= 1'b0;
          out_q <= 1'b0;
        end else begin
          s1_q  <= din_i;
          out_q <= async_i ? s1_q : din_i;
        end
      end

      p_async_two_r10: assert property (@(posedge clk) disable iff (rst)
        (arm_q == 2'd3 && $past(async_i)) |-> (out_q == $past(din_i, 2)));
    end else begin : g_raw
      always_ff @(posedge clk) begin
        if (rst) out_q <= 1'b0;
        else     out_q <= din_i;
      end
    end
  endgenerate

  // cycles since reset, saturating, for the latency checks
  always_ff @(posedge clk) begin
    if (rst)                arm_q <= 2'd0;
    else if (arm_q != 2'd3) arm_q <= arm_q + 2'd1;
  end

  p_sync_one_r9: assert property (@(posedge clk) disable iff (rst)
    (arm_q != 2'd0 && !$past(async_i)) |-> (out_q == $past(din_i)));

  assign out_o = out_q;
endmodule

// File: rtl/evt_route_top.sv
module evt_route_top
  import evt_route_pkg::*;
#(
  parameter int NCH        = 6,
  parameter int AW         = 8,
  parameter int DW         = CODE_W,
  parameter int BASE       = 16,
  parameter int NPIN       = 8,
  parameter bit SYNC_ASYNC = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [DW-1:0]     rd_data,
  input  logic              dbg_sync,
  input  logic              rtc_ovf,
  input  logic              rtc_cmp,
  input  logic [NPIT-1:0]   pit_tap,
  input  logic [NLUT-1:0]   lut_out,
  input  logic              ac_out,
  input  logic [NADC-1:0]   adc_evt,
  input  logic [NUSART-1:0] usart_xck,
  input  logic              spi_sck,
  input  logic [NTCA-1:0]   tca_evt,
  input  logic [NTCB-1:0]   tcb_evt,
  input  logic [NPIN-1:0]   pin_a,
  input  logic [NPIN-1:0]   pin_b,
  input  logic [NPIN-1:0]   pin_c,
  input  logic [NPIN-1:0]   ien_a,
  input  logic [NPIN-1:0]   ien_b,
  input  logic [NPIN-1:0]   ien_c,
  output logic [NCH-1:0]    evt_out
);
  gen_bus_t                   gen;
  logic [NPORT-1:0][NPIN-1:0] pin_m;
  logic [NCH-1:0][DW-1:0]     sel;

  assign gen = '{dbg: dbg_sync, rtc_ovf: rtc_ovf, rtc_cmp: rtc_cmp,
                 pit: pit_tap, lut: lut_out, ac: ac_out, adc: adc_evt,
                 usart: usart_xck, spi: spi_sck, tca: tca_evt, tcb: tcb_evt};

  // disabled input drivers read as zero
  assign pin_m[PORT_A] = pin_a & ien_a;
  assign pin_m[PORT_B] = pin_b & ien_b;
  assign pin_m[PORT_C] = pin_c & ien_c;

  evt_sel_regs #(.NCH(NCH), .AW(AW), .DW(DW), .BASE(BASE)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .sel_o(sel)
  );

  genvar c;
  generate
    for (c = 0; c < NCH; c++) begin : g_ch
      logic hit, asy;
      evt_chan_decode #(.CH(c), .NPIN(NPIN)) u_dec (
        .code_i(sel[c][CODE_W-1:0]), .gen_i(gen), .pin_i(pin_m),
        .hit_o(hit), .async_o(asy)
      );
      evt_chan_sync #(.SYNC_ASYNC(SYNC_ASYNC)) u_sync (
        .clk(clk), .rst(rst), .din_i(hit), .async_i(asy), .out_o(evt_out[c])
      );
    end
  endgenerate
endmodule

// File: tb/sim_evt_route_top.sv
module sim_evt_route_top;
  localparam int NV = 29;
  // {channel[2:0], code[7:0], source index[5:0], expected[0]}
  localparam logic [17:0] VEC [NV] = '{
    {3'd0, 8'h01, 6'd0,  1'b1}, {3'd1, 8'h06, 6'd1,  1'b1},
    {3'd2, 8'h07, 6'd2,  1'b1}, {3'd0, 8'h08, 6'd10, 1'b1},
    {3'd0, 8'h0B, 6'd7,  1'b1}, {3'd1, 8'h08, 6'd6,  1'b1},
    {3'd1, 8'h0B, 6'd3,  1'b1}, {3'd2, 8'h08, 6'd10, 1'b1},
    {3'd1, 8'h08, 6'd10, 1'b0}, {3'd3, 8'h13, 6'd14, 1'b1},
    {3'd4, 8'h20, 6'd15, 1'b1}, {3'd5, 8'h26, 6'd18, 1'b1},
    {3'd0, 8'h61, 6'd20, 1'b1}, {3'd1, 8'h68, 6'd21, 1'b1},
    {3'd2, 8'h81, 6'd23, 1'b1}, {3'd3, 8'h86, 6'd26, 1'b1},
    {3'd4, 8'hA3, 6'd30, 1'b1}, {3'd0, 8'h43, 6'd34, 1'b1},
    {3'd1, 8'h4F, 6'd46, 1'b1}, {3'd2, 8'h40, 6'd47, 1'b1},
    {3'd3, 8'h4A, 6'd33, 1'b1}, {3'd4, 8'h45, 6'd44, 1'b1},
    {3'd5, 8'h4C, 6'd51, 1'b1}, {3'd0, 8'h43, 6'd42, 1'b0},
    {3'd5, 8'h02, 6'd0,  1'b0}, {3'd3, 8'h00, 6'd26, 1'b0},
    {3'd4, 8'h82, 6'd23, 1'b0}, {3'd5, 8'h4C, 6'd35, 1'b0},
    {3'd3, 8'h0A, 6'd5,  1'b0}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic wr_en = 1'b0;
  logic [7:0] wr_addr = '0, wr_data = '0, rd_addr = '0, rd_data;
  logic [54:0] gen = '0;
  logic [7:0] ien_a = 8'hFF, ien_b = 8'hFF, ien_c = 8'hFF;
  logic [5:0] evt_out;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  evt_route_top u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .dbg_sync(gen[0]), .rtc_ovf(gen[1]), .rtc_cmp(gen[2]), .pit_tap(gen[10:3]),
    .lut_out(gen[14:11]), .ac_out(gen[15]), .adc_evt(gen[18:16]),
    .usart_xck(gen[20:19]), .spi_sck(gen[21]), .tca_evt(gen[26:22]),
    .tcb_evt(gen[30:27]), .pin_a(gen[38:31]), .pin_b(gen[46:39]),
    .pin_c(gen[54:47]), .ien_a(ien_a), .ien_b(ien_b), .ien_c(ien_c),
    .evt_out(evt_out)
  );

  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick(1);
    wr_en = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [7:0] d);
    rd_addr = a;
    tick(1);
    d = rd_data;
  endtask

  function automatic string tag_of(input logic [7:0] code, input logic exp);
    if (!exp)                 return "R3 undefined/foreign source blocked";
    if (code[7:3] == 5'b01000) return "R6 low pin range";
    if (code[7:3] == 5'b01001) return "R7 high pin range";
    if (code[7:2] == 6'b000010) return "R5 divider tap parity";
    return "R4 common source";
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] rv;
    @(negedge clk);
    tick(3);
    chk("R1 outputs in reset", {2'b0, evt_out}, 8'h00);
    rst = 1'b0;
    tick(1);
    for (int n = 0; n < 6; n++) begin
      rd_reg(8'h10 + 8'(n), rv);
      chk("R1 register reset value", rv, 8'h00);
    end
    chk("R1 outputs after reset", {2'b0, evt_out}, 8'h00);

    // R2 write, readback, out-of-range accesses
    wr_reg(8'h12, 8'h5A);
    rd_reg(8'h12, rv);
    chk("R2 readback ch2", rv, 8'h5A);
    wr_reg(8'h16, 8'hFF);
    wr_reg(8'h0F, 8'hFF);
    rd_reg(8'h16, rv);
    chk("R2 out-of-range read", rv, 8'h00);
    for (int n = 0; n < 6; n++) begin
      rd_reg(8'h10 + 8'(n), rv);
      chk("R2 out-of-range write ignored", rv, (n == 2) ? 8'h5A : 8'h00);
    end
    wr_reg(8'h12, 8'h00);

    // vector table
    for (int v = 0; v < NV; v++) begin
      logic [2:0] ch;
      logic [7:0] code;
      logic [5:0] idx;
      logic       ex;
      {ch, code, idx, ex} = VEC[v];
      gen = '0;
      wr_reg(8'h10 + 8'(ch), code);
      tick(3);
      gen[idx] = 1'b1;
      tick(3);
      chk(tag_of(code, ex), {7'b0, evt_out[ch]}, {7'b0, ex});
      gen[idx] = 1'b0;
      tick(3);
      chk("R3 source low gives low", {7'b0, evt_out[ch]}, 8'h00);
      wr_reg(8'h10 + 8'(ch), 8'h00);
    end

    // R8 input-enable mask
    gen = '0;
    wr_reg(8'h10, 8'h43);
    ien_a = 8'hF7;
    gen[34] = 1'b1;
    tick(3);
    chk("R8 masked pin reads zero", {7'b0, evt_out[0]}, 8'h00);
    ien_a = 8'hFF;
    tick(3);
    chk("R8 unmasked pin passes", {7'b0, evt_out[0]}, 8'h01);
    gen = '0;
    wr_reg(8'h10, 8'h00);

    // R9 synchronous latency: one edge
    wr_reg(8'h10, 8'h24);
    tick(3);
    gen[16] = 1'b1;
    tick(1);
    chk("R9 sync source after one edge", {7'b0, evt_out[0]}, 8'h01);
    gen[16] = 1'b0;
    tick(1);
    chk("R9 sync source falls after one edge", {7'b0, evt_out[0]}, 8'h00);

    // R10 asynchronous latency: two edges
    wr_reg(8'h11, 8'h06);
    tick(3);
    gen[1] = 1'b1;
    tick(1);
    chk("R10 async source not yet through", {7'b0, evt_out[1]}, 8'h00);
    tick(1);
    chk("R10 async source after two edges", {7'b0, evt_out[1]}, 8'h01);
    gen = '0;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule